// File: doc/BRIEF.md
# Serial Floor and Ceiling Parameter Registers

This block is a write-only serial slave that holds the scene parameters a beam-racing renderer needs apart from the viewpoint. It holds the ceiling colour, the floor colour and a 6-bit floor leak amount. A host sends 10-bit frames over a chip select, a serial clock and a data line. Each frame carries a 4-bit register select and then a 6-bit payload. The three serial inputs are asynchronous to the system clock, so they pass through synchroniser flops before any edge is detected.

A frame that is accepted goes into a staging copy of its register. The values the renderer sees change only when a vertical-blank start pulse arrives. This means a write that lands in the middle of a frame can never tear the picture. The host may write at any time and at any rate. The last complete write before a blank is the one that takes effect.

Top module: `scene_param_spi`

## Requirements
- R1: After reset the ceiling output is 6'b010101 (dark grey), the floor output is 6'b101010 (light grey) and the leak output is 0.
- R2: While `cs_n` is low, a bit is sampled from `mosi` on each rising edge of `sck`. The bits form a frame sent most significant bit first: frame bits [9:6] are the select and frame bits [5:0] are the payload.
- R3: A frame is accepted only if exactly 10 rising `sck` edges occur between the fall and the rise of `cs_n`. A frame of any other length changes no register.
- R4: Select 0 writes the ceiling, select 1 writes the floor and select 2 writes the leak value. Selects 3 to 15 change no register.
- R5: The payload is stored unchanged. For colours, bits [5:4] are blue, bits [3:2] are green and bits [1:0] are red. The leak value is an unsigned number from 0 to 63.
- R6: Accepted values do not appear on the outputs until `vblank_start` is sampled high. The outputs then show the staged values from the next clock edge, and they hold steady between such pulses.
- R7: When several frames write the same register before one `vblank_start`, the last accepted frame is the one that appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial chip select, active low, asynchronous |
| sck | input | 1 | Serial clock, asynchronous |
| mosi | input | 1 | Serial data in, asynchronous |
| vblank_start | input | 1 | One-cycle pulse at the start of vertical blank |
| ceil_rgb | output | 6 | Live ceiling colour, BBGGRR |
| floor_rgb | output | 6 | Live floor colour, BBGGRR |
| floor_leak | output | 6 | Live floor leak value |

## Verification
A frame is decoded into staging a few system cycles after `cs_n` rises: the synchroniser depth, plus one edge-detect flop, plus one decode flop. The bench therefore waits twelve cycles after raising `cs_n` before it pulses `vblank_start`. The live outputs load on the clock edge that samples the pulse. Each check is taken on the falling edge that follows that edge. The outputs are also checked just before the pulse, to show that a staged value has not yet leaked through.

// File: rtl/scene_param_pkg.sv
package scene_param_pkg;

   localparam int SEL_W    = 4;
   localparam int DATA_W   = 6;
   localparam int NUM_REGS = 3;

   typedef enum logic [SEL_W-1:0] {
      SEL_CEIL  = 4'd0,
      SEL_FLOOR = 4'd1,
      SEL_LEAK  = 4'd2
   } param_sel_e;

   // Power-on contents, indexed by select code
   function automatic logic [DATA_W-1:0] reset_word(int idx);
      case (idx)
         int'(SEL_CEIL):  return 6'b010101;
         int'(SEL_FLOOR): return 6'b101010;
         default:         return '0;
      endcase
   endfunction

endpackage

// File: rtl/sig_sync.sv
module sig_sync #(
   parameter int             WIDTH     = 3,
   parameter int             STAGES    = 2,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sig_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            chain[s] <= RESET_VAL;
         else if (s == 0)
            chain[s] <= async_i;
         else
            chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/frame_rx.sv
module frame_rx #(
   parameter int SEL_W  = 4,
   parameter int DATA_W = 6,
   localparam int FRAME_BITS = SEL_W + DATA_W,
   localparam int CNT_W      = $clog2(FRAME_BITS + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_s,
   input  logic              sck_s,
   input  logic              mosi_s,
   output logic              frame_ok,
   output logic [SEL_W-1:0]  frame_sel,
   output logic [DATA_W-1:0] frame_data
);

   if (SEL_W < 1 || DATA_W < 1) begin : g_bad_widths
      $error("frame_rx: field widths must be positive");
   end

   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_BITS);
   localparam logic [CNT_W-1:0] OVER_CNT = CNT_W'(FRAME_BITS + 1);

   logic                  sck_q, cs_q;
   logic                  sck_rise, cs_rise;
   logic [CNT_W-1:0]      bit_cnt;
   logic [FRAME_BITS-1:0] shreg;

   assign sck_rise = sck_s & ~sck_q;
   assign cs_rise  = cs_n_s & ~cs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0;
         cs_q  <= 1'b1;
      end else begin
         sck_q <= sck_s;
         cs_q  <= cs_n_s;
      end
   end

   // Count saturates one past a full frame so over-long frames stay rejected
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         shreg   <= '0;
      end else if (cs_n_s) begin
         bit_cnt <= '0;
      end else if (sck_rise) begin
         shreg <= {shreg[FRAME_BITS-2:0], mosi_s};
         if (bit_cnt != OVER_CNT)
            bit_cnt <= bit_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_ok   <= 1'b0;
         frame_sel  <= '0;
         frame_data <= '0;
      end else begin
         frame_ok <= cs_rise && (bit_cnt == FULL_CNT);
         if (cs_rise) begin
            frame_sel  <= shreg[FRAME_BITS-1:DATA_W];
            frame_data <= shreg[DATA_W-1:0];
         end
      end
   end

   a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= OVER_CNT);

   a_r3_single_accept: assert property (@(posedge clk) disable iff (!rst_n)
      frame_ok |=> !frame_ok);

endmodule

// File: rtl/param_regfile.sv
module param_regfile
   import scene_param_pkg::*;
#(
   parameter int SEL_W_P  = SEL_W,
   parameter int DATA_W_P = DATA_W,
   parameter int REGS     = NUM_REGS
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [SEL_W_P-1:0]             wr_sel,
   input  logic [DATA_W_P-1:0]            wr_data,
   input  logic                           commit,
   output logic [REGS-1:0][DATA_W_P-1:0]  live_o
);

   if (DATA_W_P != DATA_W) begin : g_bad_data
      $error("param_regfile: data width must match package reset table");
   end
   if (REGS > (1 << SEL_W_P)) begin : g_bad_regs
      $error("param_regfile: more registers than select codes");
   end

   logic [REGS-1:0][DATA_W_P-1:0] staged;

   for (genvar i = 0; i < REGS; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            staged[i] <= reset_word(i);
         else if (wr_en && (wr_sel == SEL_W_P'(i)))
            staged[i] <= wr_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            live_o[i] <= reset_word(i);
         else if (commit)
            live_o[i] <= staged[i];
      end
   end

   a_r6_hold_between_blanks: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(live_o));

   a_r6_commit_loads_staged: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (live_o == $past(staged)));

   a_r4_unused_select: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_sel >= SEL_W_P'(REGS))) |=> $stable(staged));

endmodule

// File: rtl/scene_param_spi.sv
module scene_param_spi
   import scene_param_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sck,
   input  logic              mosi,
   input  logic              vblank_start,
   output logic [DATA_W-1:0] ceil_rgb,
   output logic [DATA_W-1:0] floor_rgb,
   output logic [DATA_W-1:0] floor_leak
);

   logic [2:0]                    pins_s;
   logic                          frame_ok;
   logic [SEL_W-1:0]              frame_sel;
   logic [DATA_W-1:0]             frame_data;
   logic [NUM_REGS-1:0][DATA_W-1:0] live;

   sig_sync #(
      .WIDTH     (3),
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (3'b100)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({cs_n, sck, mosi}),
      .sync_o  (pins_s)
   );

   frame_rx #(
      .SEL_W  (SEL_W),
      .DATA_W (DATA_W)
   ) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_n_s     (pins_s[2]),
      .sck_s      (pins_s[1]),
      .mosi_s     (pins_s[0]),
      .frame_ok   (frame_ok),
      .frame_sel  (frame_sel),
      .frame_data (frame_data)
   );

   param_regfile #(
      .SEL_W_P  (SEL_W),
      .DATA_W_P (DATA_W),
      .REGS     (NUM_REGS)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (frame_ok),
      .wr_sel  (frame_sel),
      .wr_data (frame_data),
      .commit  (vblank_start),
      .live_o  (live)
   );

   assign ceil_rgb   = live[int'(SEL_CEIL)];
   assign floor_rgb  = live[int'(SEL_FLOOR)];
   assign floor_leak = live[int'(SEL_LEAK)];

   a_r1_reset_grey: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (ceil_rgb == 6'b010101 && floor_rgb == 6'b101010));

endmodule

// File: tb/scene_param_spi_test.sv
`timescale 1ns/1ps
module scene_param_spi_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, vblank_start = 1'b0;
   logic [5:0] ceil_rgb, floor_rgb, floor_leak;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [5:0] exp_live [3];
   logic [5:0] exp_stage [3];

   always #4 clk = ~clk;

   scene_param_spi uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
      .vblank_start(vblank_start), .ceil_rgb(ceil_rgb),
      .floor_rgb(floor_rgb), .floor_leak(floor_leak)
   );

   task automatic check_out(string tag);
      checks++;
      if (ceil_rgb !== exp_live[0] || floor_rgb !== exp_live[1] ||
          floor_leak !== exp_live[2]) begin
         errors++;
         $display("FAIL %s: actual %b/%b/%b expected %b/%b/%b", tag,
                  ceil_rgb, floor_rgb, floor_leak,
                  exp_live[0], exp_live[1], exp_live[2]);
      end
   endtask

   task automatic send_bits(int n, logic [15:0] w);
      @(negedge clk) cs_n = 1'b0;
      repeat (8) @(negedge clk);
      for (int i = n - 1; i >= 0; i--) begin
         mosi = w[i];
         repeat (8) @(negedge clk);
         sck = 1'b1;
         repeat (8) @(negedge clk);
         sck = 1'b0;
      end
      repeat (8) @(negedge clk);
      cs_n = 1'b1;
      repeat (12) @(negedge clk);
   endtask

   // Model of an accepted 10-bit frame: select in [9:6], payload in [5:0]
   task automatic write_reg(int sel, logic [5:0] v);
      send_bits(10, {6'd0, 4'(sel), v});
      if (sel < 3) exp_stage[sel] = v;
   endtask

   task automatic blank();
      @(negedge clk) vblank_start = 1'b1;
      @(negedge clk) vblank_start = 1'b0;
      for (int k = 0; k < 3; k++) exp_live[k] = exp_stage[k];
   endtask

   initial begin
      exp_live[0] = 6'b010101; exp_live[1] = 6'b101010; exp_live[2] = 6'd0;
      for (int k = 0; k < 3; k++) exp_stage[k] = exp_live[k];
      repeat (5) @(negedge clk);
      check_out("R1 reset state during reset");
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check_out("R1 reset state");

      // R2/R4/R5/R6: sweep every payload into every register
      for (int v = 0; v < 64; v++) begin
         for (int s = 0; s < 3; s++) begin
            write_reg(s, 6'(v));
            check_out("R6 staged value not visible before blank");
            blank();
            check_out("R2 R4 value after blank");
         end
      end

      // R5: channel fields of a colour
      write_reg(0, 6'b110100);
      blank();
      checks++;
      if (ceil_rgb[5:4] !== 2'd3 || ceil_rgb[3:2] !== 2'd1 || ceil_rgb[1:0] !== 2'd0) begin
         errors++;
         $display("FAIL R5 channel fields: actual %b expected 110100", ceil_rgb);
      end

      // R4: unused selects are ignored
      for (int s = 3; s < 16; s++) begin
         write_reg(s, 6'b100111);
         blank();
         check_out("R4 unused select ignored");
      end

      // R3: wrong lengths are discarded
      send_bits(9, 16'h017F);
      blank();
      check_out("R3 nine-bit frame ignored");
      send_bits(11, 16'h003F);
      blank();
      check_out("R3 eleven-bit frame ignored");
      send_bits(0, 16'h0000);
      blank();
      check_out("R3 empty frame ignored");

      // R7: last write before a blank wins
      write_reg(1, 6'b000011);
      write_reg(1, 6'b110000);
      write_reg(2, 6'd7);
      write_reg(2, 6'd63);
      check_out("R6 nothing visible before blank");
      blank();
      check_out("R7 last write wins");

      // R6: outputs stay put with no blank
      repeat (50) @(negedge clk);
      check_out("R6 hold without blank");

      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule